// File: doc/BRIEF.md
# Event-Gated Programmable Clock Divider

The block turns a selected master-rate strobe into a square-wave output clock whose period is a programmed number of master cycles. Sixteen clock-bus lines arrive as strobes. The master select picks one of them, and every system clock cycle in which that line is high counts as one master cycle.

Generation is armed by an enable. It begins either right away or on a rising edge of a selectable event line. The event lines are the clock-bus lines and a bank of interrupt lines, indexed together by one select code. Generation ends when the enable drops, when a selectable stop event rises, or, in one-shot mode, after a programmed number of output periods. In one-shot mode the block then waits in idle for the next start.

A rising edge means the selected line is high in this system clock sample and was low in the sample before. The edge detectors reset to low.

Top module: `pcg_clkgen`

## Requirements
- R1: After reset, `clk_out` and `running` are both 0.
- R2: In continuous mode with period value P ≥ 2, `clk_out` repeats every P master cycles. It is high for floor(P/2) master cycles and low for the rest.
- R3: A period value of 0 or 1 behaves exactly like 2.
- R4: One master cycle is counted in each system clock cycle in which `clk_bus[mclk_sel]` is high. A line that is high only every k-th cycle therefore stretches both output phases by k.
- R5: With `start_sel` = 0, generation begins at the first clock edge at which `en` is seen high after being low. At that edge `running` and `clk_out` both go to 1.
- R6: With `start_sel` from 1 to 15, an idle, enabled block starts at the clock edge that sees a rising edge on `clk_bus[start_sel]`. Without such an edge it stays idle.
- R7: With `start_sel` from 16 to 31, the start line is `irq_bus[start_sel-16]`.
- R8: With `stop_sel` nonzero, a rising edge on the selected line while running returns the block to idle. `running` and `clk_out` are both 0 after that edge. `stop_sel` uses the same line mapping as `start_sel`.
- R9: With `stop_sel` = 0, edges on the event lines never stop generation.
- R10: In one-shot mode, exactly `count` high pulses appear (a count of 0 acts as 1), and then the block is idle. It stays idle until a new start condition occurs.
- R11: When `en` is low at a clock edge, the block is idle with `clk_out` low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable |
| one_shot | input | 1 | 1: stop after `count` periods; 0: continuous |
| mclk_sel | input | 4 | Master strobe line select |
| start_sel | input | 5 | Start event select, 0 = start when enabled |
| stop_sel | input | 5 | Stop event select, 0 = no stop event |
| period | input | 16 | Output period in master cycles |
| count | input | 16 | One-shot period count |
| clk_bus | input | 16 | Clock-bus strobe lines |
| irq_bus | input | 16 | Interrupt event lines |
| clk_out | output | 1 | Generated clock |
| running | output | 1 | High while generating |

## Verification
The hardest case to reach is the steady-state phase timing when the master strobe is sparse. Each phase only advances on strobe cycles, so the first pulse after a start is not representative. The bench therefore feeds strobes at every cycle, every second cycle and every third cycle, combined with random periods that include 0 and 1. It measures the second full pulse, not the first. Start and stop events are driven on exact cycles, on both a clock-bus line and an interrupt line. The one-shot pulse count is checked for a count of 0 and for random counts.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} pcg_state_e;

   // smallest legal divide ratio
   localparam int MIN_DIV = 2;
endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
   parameter int W      = 32,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pcg_evsel.sv
module pcg_evsel #(
   parameter int W     = 32,
   localparam int SW   = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  lines,
   input  logic [SW-1:0] sel_a,
   input  logic [SW-1:0] sel_b,
   output logic          hit_a,
   output logic          hit_b
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines;
   end

   assign rise  = lines & ~prev_q;
   // code 0 never selects a line
   assign hit_a = (sel_a != '0) && rise[sel_a];
   assign hit_b = (sel_b != '0) && rise[sel_b];
endmodule

// File: rtl/pcg_divider.sv
module pcg_divider
   import pcg_pkg::*;
#(
   parameter int PER_W = 16,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             halt,
   input  logic             tick,
   input  logic             one_shot,
   input  logic [PER_W-1:0] period,
   input  logic [CNT_W-1:0] count,
   output logic             out,
   output logic             active
);
   localparam logic [PER_W-1:0] DIV_MIN = PER_W'(MIN_DIV);

   pcg_state_e       st_q;
   logic [PER_W-1:0] ph_q;
   logic [CNT_W-1:0] np_q;
   logic             out_q;

   logic [PER_W-1:0] eff, half, ph_nx;
   logic [CNT_W:0]   np_nx, lim;
   logic             wrap, last;

   assign eff   = (period < DIV_MIN) ? DIV_MIN : period;
   assign half  = eff >> 1;
   assign ph_nx = ph_q + 1'b1;
   assign wrap  = (ph_q == eff - 1'b1);
   assign np_nx = {1'b0, np_q} + 1'b1;
   assign lim   = (count == '0) ? (CNT_W+1)'(1) : {1'b0, count};
   assign last  = one_shot && (np_nx >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ph_q  <= '0;
         np_q  <= '0;
         out_q <= 1'b0;
      end else if (halt) begin
         st_q  <= ST_IDLE;
         out_q <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         if (start) begin
            st_q  <= ST_RUN;
            ph_q  <= '0;
            np_q  <= '0;
            out_q <= 1'b1;
         end
      end else if (tick) begin
         if (wrap) begin
            ph_q <= '0;
            np_q <= np_nx[CNT_W-1:0];
            if (last) begin
               st_q  <= ST_IDLE;
               out_q <= 1'b0;
            end else begin
               out_q <= 1'b1;
            end
         end else begin
            ph_q  <= ph_nx;
            out_q <= (ph_nx < half);
         end
      end
   end

   assign out    = out_q;
   assign active = (st_q == ST_RUN);
endmodule

// File: rtl/pcg_clkgen.sv
module pcg_clkgen #(
   parameter int CLK_LINES   = 16,
   parameter int IRQ_LINES   = 16,
   parameter int PER_W       = 16,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     en,
   input  logic                                     one_shot,
   input  logic [$clog2(CLK_LINES)-1:0]             mclk_sel,
   input  logic [$clog2(CLK_LINES+IRQ_LINES)-1:0]   start_sel,
   input  logic [$clog2(CLK_LINES+IRQ_LINES)-1:0]   stop_sel,
   input  logic [PER_W-1:0]                         period,
   input  logic [CNT_W-1:0]                         count,
   input  logic [CLK_LINES-1:0]                     clk_bus,
   input  logic [IRQ_LINES-1:0]                     irq_bus,
   output logic                                     clk_out,
   output logic                                     running
);
   localparam int EV_W = CLK_LINES + IRQ_LINES;

   generate
      if ((CLK_LINES & (CLK_LINES - 1)) != 0 || CLK_LINES < 2) begin : g_bad_lines
         $error("CLK_LINES must be a power of two, at least 2");
      end
      if (IRQ_LINES != CLK_LINES) begin : g_bad_irq
         $error("IRQ_LINES must equal CLK_LINES");
      end
      if (PER_W < 2 || CNT_W < 1) begin : g_bad_w
         $error("PER_W must be at least 2 and CNT_W at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   logic [EV_W-1:0] ev_raw, ev_s;
   logic            start_hit, stop_hit;
   logic            en_q, tick, start, halt, active;

   assign ev_raw = {irq_bus, clk_bus};

   pcg_sync #(.W(EV_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ev_raw), .q(ev_s)
   );

   pcg_evsel #(.W(EV_W)) u_evsel (
      .clk(clk), .rst_n(rst_n), .lines(ev_s),
      .sel_a(start_sel), .sel_b(stop_sel),
      .hit_a(start_hit), .hit_b(stop_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end

   assign tick  = clk_bus[mclk_sel];
   assign start = en && ((start_sel == '0) ? !en_q : start_hit);
   assign halt  = !en || (active && stop_hit);

   pcg_divider #(.PER_W(PER_W), .CNT_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .tick(tick),
      .one_shot(one_shot), .period(period), .count(count),
      .out(clk_out), .active(active)
   );

   assign running = active;
endmodule

// File: rtl/pcg_clkgen_chk.sv
module pcg_clkgen_chk #(
   parameter int CLK_LINES   = 16,
   parameter int IRQ_LINES   = 16,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input logic                                   clk,
   input logic                                   rst_n,
   input logic                                   en,
   input logic                                   one_shot,
   input logic [$clog2(CLK_LINES+IRQ_LINES)-1:0] start_sel,
   input logic [$clog2(CLK_LINES+IRQ_LINES)-1:0] stop_sel,
   input logic [CNT_W-1:0]                       count,
   input logic [CLK_LINES-1:0]                   clk_bus,
   input logic [IRQ_LINES-1:0]                   irq_bus,
   input logic                                   clk_out,
   input logic                                   running
);
   localparam int EV_W = CLK_LINES + IRQ_LINES;

   logic [EV_W-1:0]  vec, prev_vec;
   logic             out_prev;
   logic [CNT_W:0]   seen, lim;
   logic             stop_rise, start_rise;

   assign vec        = {irq_bus, clk_bus};
   assign stop_rise  = vec[stop_sel] && !prev_vec[stop_sel];
   assign start_rise = vec[start_sel] && !prev_vec[start_sel];
   assign lim        = (count == '0) ? (CNT_W+1)'(1) : {1'b0, count};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_vec <= '0;
         out_prev <= 1'b0;
         seen     <= '0;
      end else begin
         prev_vec <= vec;
         out_prev <= clk_out;
         if (!running)                  seen <= '0;
         else if (clk_out && !out_prev) seen <= seen + 1'b1;
      end
   end

   // R11
   en_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!running && !clk_out));

   // R8
   stop_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SYNC_STAGES == 0 && running && stop_sel != '0 && stop_rise) |=> !running);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SYNC_STAGES == 0 && !running && start_sel != '0 && !start_rise) |=> !running);

   // R2
   out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out) |-> running);

   // R10
   oneshot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && one_shot) |-> (seen <= lim));
endmodule

bind pcg_clkgen pcg_clkgen_chk #(
   .CLK_LINES(CLK_LINES), .IRQ_LINES(IRQ_LINES), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .one_shot(one_shot),
   .start_sel(start_sel), .stop_sel(stop_sel), .count(count),
   .clk_bus(clk_bus), .irq_bus(irq_bus), .clk_out(clk_out), .running(running)
);

// File: tb/tb_pcg_clkgen.sv
`timescale 1ns/1ps
module tb_pcg_clkgen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, one_shot = 1'b0;
   logic [3:0]  mclk_sel = 4'd1;
   logic [4:0]  start_sel = '0, stop_sel = '0;
   logic [15:0] period = 16'd4, count = 16'd1;
   logic        trig_a = 1'b0, irq_t = 1'b0, ph2 = 1'b0;
   logic [1:0]  ph3 = '0;
   logic [15:0] clk_bus, irq_bus;
   logic        clk_out, running;

   int tests = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   // strobe patterns: line1 every cycle, line2 every 2nd, line4 every 3rd, line7 event
   always @(negedge clk) begin
      ph2 <= ~ph2;
      ph3 <= (ph3 == 2'd2) ? 2'd0 : ph3 + 2'd1;
   end
   assign clk_bus = {8'b0, trig_a, 2'b0, (ph3 == 2'd0), 1'b0, ph2, 1'b1, 1'b1};
   assign irq_bus = {10'b0, irq_t, 5'b0};

   pcg_clkgen dut (
      .clk(clk), .rst_n(rst_n), .en(en), .one_shot(one_shot), .mclk_sel(mclk_sel),
      .start_sel(start_sel), .stop_sel(stop_sel), .period(period), .count(count),
      .clk_bus(clk_bus), .irq_bus(irq_bus), .clk_out(clk_out), .running(running)
   );

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rise();
      int p = clk_out;
      for (int g = 0; g < 5000; g++) begin
         @(negedge clk);
         if (p == 0 && clk_out == 1) return;
         p = clk_out;
      end
   endtask

   task automatic measure(output int hi, output int lo);
      wait_rise();
      wait_rise();
      hi = 0; lo = 0;
      while (clk_out && hi < 5000) begin hi++; @(negedge clk); end
      while (!clk_out && lo < 5000) begin lo++; @(negedge clk); end
   endtask

   function automatic int eff_of(int p);
      return (p < 2) ? 2 : p;
   endfunction

   task automatic idle_all();
      en = 1'b0; one_shot = 1'b0; start_sel = '0; stop_sel = '0;
      trig_a = 1'b0; irq_t = 1'b0;
      step(3);
   endtask

   task automatic run_cont(int p, int line, int k, string req);
      int hi, lo, e;
      idle_all();
      period = 16'(p); mclk_sel = 4'(line);
      en = 1'b1;
      measure(hi, lo);
      e = eff_of(p);
      chk({req, " high"}, hi, (e / 2) * k);
      chk({req, " low"}, lo, (e - e / 2) * k);
   endtask

   task automatic run_oneshot(int n);
      int rises = 0, p = 0;
      idle_all();
      period = 16'd3; mclk_sel = 4'd1; count = 16'(n); one_shot = 1'b1;
      en = 1'b1;
      for (int g = 0; g < 2000; g++) begin
         @(negedge clk);
         if (p == 0 && clk_out == 1) rises++;
         p = clk_out;
         if (!running) break;
      end
      chk("R10 pulse count", rises, (n == 0) ? 1 : n);
      step(10);
      chk("R10 stays idle", running, 0);
   endtask

   initial begin
      int lines[3] = '{1, 2, 4};
      int ks[3]    = '{1, 2, 3};
      void'($urandom(32'd1234));
      step(3);
      chk("R1 clk_out at reset", clk_out, 0);
      chk("R1 running at reset", running, 0);
      rst_n = 1'b1;
      step(2);
      chk("R1 after release", running, 0);

      // R5 immediate start
      idle_all();
      en = 1'b1;
      step(1);
      chk("R5 running after en rise", running, 1);
      chk("R5 clk_out after en rise", clk_out, 1);

      // R11 enable drop
      en = 1'b0;
      step(1);
      chk("R11 running", running, 0);
      chk("R11 clk_out", clk_out, 0);

      // R2 / R3 / R4 directed
      run_cont(4, 1, 1, "R2 p4");
      run_cont(7, 1, 1, "R2 p7");
      run_cont(0, 1, 1, "R3 p0");
      run_cont(1, 1, 1, "R3 p1");
      run_cont(5, 2, 2, "R4 every2");
      run_cont(6, 4, 3, "R4 every3");

      // random mix
      for (int t = 0; t < 12; t++) begin
         int s = $urandom_range(0, 2);
         run_cont($urandom_range(0, 14), lines[s], ks[s], "R2 random");
      end

      // R6 start on clock-bus line 7
      idle_all();
      period = 16'd4; mclk_sel = 4'd1; start_sel = 5'd7;
      en = 1'b1;
      step(6);
      chk("R6 no edge stays idle", running, 0);
      trig_a = 1'b1;
      step(1);
      chk("R6 start on edge", running, 1);

      // R9 no stop event
      step(3); trig_a = 1'b0; irq_t = 1'b1; step(2); trig_a = 1'b1; step(20);
      chk("R9 keeps running", running, 1);

      // R8 stop on line 7
      trig_a = 1'b0; stop_sel = 5'd7;
      step(5);
      chk("R8 still running before edge", running, 1);
      trig_a = 1'b1;
      step(1);
      chk("R8 running after stop", running, 0);
      chk("R8 clk_out after stop", clk_out, 0);

      // R7 start on interrupt line 5 (code 21), stop on same
      idle_all();
      start_sel = 5'd21;
      en = 1'b1;
      step(4);
      chk("R7 idle before irq", running, 0);
      irq_t = 1'b1;
      step(1);
      chk("R7 start on irq", running, 1);
      irq_t = 1'b0; stop_sel = 5'd21;
      step(4);
      irq_t = 1'b1;
      step(1);
      chk("R8 stop on irq line", running, 0);

      // R10 one-shot
      run_oneshot(0);
      run_oneshot(1);
      for (int t = 0; t < 3; t++) run_oneshot($urandom_range(2, 6));

      idle_all();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule